// File: doc/BRIEF.md
# Source-Selectable Timer Prescaler

This block divides a chosen stream of source events by a programmable factor and emits a one-cycle tick for the timers that follow it. Each source event is either a strobe that fires on every second cycle of the internal clock, or a rising edge seen on one of three asynchronous timer pins. The pins are first brought into the internal clock domain. A single 16-bit configuration word holds a 14-bit preload count and a 2-bit source selector. The word can be written and read back at any time.

A down counter is loaded with the preload count on the first enabled cycle. After that it drops by one for each qualified event. When the counter is already at zero and an event arrives, the block raises the tick for one cycle and loads the preload count again. A preload of N therefore gives one tick for every N+1 events. While the enable input is low, no ticks come out. When the enable rises again, the count restarts from the preload that is stored at that moment.

Top module: `tick_prescaler`

## Requirements
- R1: Hardware reset (rst_n low) and the synchronous software clear (soft_clr high) both set the configuration word to 0x0000 and hold tick_o low. The software clear takes priority over a write in the same cycle.
- R2: A write (wr_en high at a clock edge) stores wr_data. From the next cycle, rd_data returns that value. Bits 13:0 are the preload count and bits 15:14 are the source selector.
- R3: With preload N, exactly one tick is produced for every N+1 qualified source events. Each tick lasts a single clock cycle.
- R4: Selector 00 uses an internal strobe that is active on every second enabled cycle, starting with the second enabled cycle. The first tick therefore appears 2(N+1) clock edges after the enable is first seen, and later ticks repeat with that same period.
- R5: The first cycle in which run_en is seen high after being low only loads the preload count. No tick is produced in that cycle, and any event arriving in that cycle is not counted. A changed preload takes effect at the next enable.
- R6: While run_en is low, tick_o stays low.
- R7: Selectors 01, 10 and 11 use pin_async[0], [1] and [2]. Each pin passes through a two-flop synchronizer and a rising-edge detector. A rise driven before clock edge k produces its tick (for preload 0) at edge k+2.
- R8: Falling pin edges, and edges on pins that are not selected, are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| soft_clr | input | 1 | Synchronous software clear of configuration and count |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 16 | Configuration word to write |
| rd_data | output | 16 | Stored configuration word |
| run_en | input | 1 | Prescaler enable |
| pin_async | input | 3 | Asynchronous timer pins usable as event sources |
| tick_o | output | 1 | One-cycle prescaled tick |

## Verification
The hardest case to reach from the ports is the tick timing for an external pin. The pin has to cross the synchronizer and the edge detector, and it must not land on the reload cycle or be mixed up with activity on the other pins. The bench first settles every pin low and lets the enable-time reload finish. Only then does it raise the selected pin and count clock edges up to the tick. Random runs send pulses of random width on the selected pin while the unselected pins toggle at random, and compare the tick count with the number of rising edges divided by N+1.

// File: rtl/tick_prescaler_pkg.sv
// Package: shared constants and types for the timer prescaler.
// Assumes the configuration word is laid out as {selector, preload}.
package tick_prescaler_pkg;
    localparam int CFG_W       = 16;
    localparam int PL_W        = 14;
    localparam int SEL_W       = CFG_W - PL_W;
    localparam int N_PINS      = 3;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_HALF = 2'b00,
        SRC_PIN0 = 2'b01,
        SRC_PIN1 = 2'b10,
        SRC_PIN2 = 2'b11
    } src_sel_e;

    typedef struct packed {
        src_sel_e              src;
        logic [PL_W-1:0]       preload;
    } cfg_t;
endpackage

// File: rtl/tp_cfg_reg.sv
// Module: configuration word holder.
// Stores the preload count and source selector on a write strobe.
// Assumes soft_clr takes priority over a simultaneous write.
module tp_cfg_reg
    import tick_prescaler_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             cfg_q
);
    // Capture a new configuration or clear it on either reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (soft_clr) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= cfg_t'(wr_data);
        end
    end
endmodule

// File: rtl/tp_pin_edge.sv
// Module: synchronizer and rising-edge detector for one pin.
// Brings an asynchronous pin through STAGES flops, then flags a low-to-high
// change with a single-cycle pulse. Assumes the pin stays in each level for
// at least two internal clock cycles. The software clear leaves this stage alone
// so that clearing cannot manufacture a false edge.
module tp_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise
);
    localparam int MSB = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              hist_q;

    // Shift the pin through the synchronizer and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[MSB-1:0], pin_async};
            hist_q <= sync_q[MSB];
        end
    end

    // Flag the cycle in which the synchronized level first reads high.
    always_comb begin
        rise = sync_q[MSB] & ~hist_q;
    end
endmodule

// File: rtl/tp_source_mux.sv
// Module: event source selection.
// Produces the internal half-rate strobe and picks one event stream by the
// selector. The strobe is held in phase 0 while disabled, so the first
// enabled cycle carries no event and the second one does.
// Assumes the selector changes only while disabled.
module tp_source_mux #(
    parameter int NPINS = 3,
    parameter int SELW  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             run_en,
    input  logic [SELW-1:0]  sel,
    input  logic [NPINS-1:0] pin_rise,
    output logic             evt
);
    logic half_q;
    logic picked;

    // Toggle the half-rate phase while enabled; park it at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else if (soft_clr || !run_en) begin
            half_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
        end
    end

    // Choose the strobe for selector zero, otherwise pin (selector - 1).
    always_comb begin
        picked = 1'b0;
        if (sel == '0) begin
            picked = half_q;
        end else begin
            for (int i = 0; i < NPINS; i++) begin
                if (int'(sel) == i + 1) begin
                    picked = pin_rise[i];
                end
            end
        end
        evt = run_en & picked;
    end
endmodule

// File: rtl/tp_down_counter.sv
// Module: reloading down counter with tick output.
// Loads the preload on the first enabled cycle and ignores any event in
// that cycle. Afterwards it decrements per event, and on an event at zero
// it raises a one-cycle tick and reloads. While disabled it holds its count.
module tp_down_counter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic         run_en,
    input  logic         evt,
    input  logic [W-1:0] preload,
    output logic         tick
);
    logic [W-1:0] cnt_q;
    logic         en_q;
    logic         start;
    logic         at_zero;

    // Detect the disabled-to-enabled step and the terminal count.
    always_comb begin
        start   = run_en & ~en_q;
        at_zero = (cnt_q == '0);
    end

    // Advance the count, reload it and generate the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
            tick  <= 1'b0;
        end else if (soft_clr) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
            tick  <= 1'b0;
        end else begin
            en_q <= run_en;
            tick <= 1'b0;
            if (start) begin
                cnt_q <= preload;
            end else if (evt) begin
                if (at_zero) begin
                    tick  <= 1'b1;
                    cnt_q <= preload;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tick_prescaler.sv
// Module: timer prescaler top level.
// Divides a selected event stream (internal half-rate strobe or a rising
// edge on one of the pins) by preload+1 and emits one-cycle ticks.
// Assumes external pin rates below a quarter of clk and selector changes
// only while run_en is low.
module tick_prescaler
    import tick_prescaler_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_data,
    output logic [CFG_W-1:0]  rd_data,
    input  logic              run_en,
    input  logic [N_PINS-1:0] pin_async,
    output logic              tick_o
);
    cfg_t              cfg_q;
    logic [N_PINS-1:0] pin_rise;
    logic              evt;

    tp_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cfg_q    (cfg_q)
    );

    // One synchronizer and edge detector per pin.
    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        tp_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pin_async[g]),
            .rise      (pin_rise[g])
        );
    end

    tp_source_mux #(.NPINS(N_PINS), .SELW(SEL_W)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .run_en   (run_en),
        .sel      (cfg_q.src),
        .pin_rise (pin_rise),
        .evt      (evt)
    );

    tp_down_counter #(.W(PL_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .run_en   (run_en),
        .evt      (evt),
        .preload  (cfg_q.preload),
        .tick     (tick_o)
    );

    // Read port returns the stored configuration word.
    always_comb begin
        rd_data = cfg_q;
    end
endmodule

// File: rtl/tick_prescaler_chk.sv
// Module: property checker for the prescaler, bound to every instance.
module tick_prescaler_chk
    import tick_prescaler_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              soft_clr,
    input logic              wr_en,
    input logic [CFG_W-1:0]  wr_data,
    input logic [CFG_W-1:0]  rd_data,
    input logic              run_en,
    input logic [N_PINS-1:0] pin_async,
    input logic              tick_o
);
    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (rd_data == '0) && !tick_o);

    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_clr) |=> rd_data == $past(wr_data));

    assert_single_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    assert_no_tick_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |=> !tick_o);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !tick_o);

    assert_cfg_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !soft_clr) |=> $stable(rd_data));
endmodule

bind tick_prescaler tick_prescaler_chk u_chk (.*);

// File: tb/test_tick_prescaler.sv
`timescale 1ns/1ps
module test_tick_prescaler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        run_en = 1'b0;
    logic [2:0]  pin_async = '0;
    logic        tick_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    tick_prescaler i_tick_prescaler (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_int_ticks(input int n, input int edges);
        return edges / (2 * (n + 1));
    endfunction

    function automatic int exp_ext_ticks(input int n, input int rises);
        return rises / (n + 1);
    endfunction

    task automatic write_cfg(input int pl, input int ps);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = {ps[1:0], pl[13:0]};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Counts negedges after the enable until a tick, bounded by lim.
    task automatic edges_to_tick(input int lim, output int c);
        c = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            c++;
            if (tick_o) return;
        end
        c = -1;
    endtask

    task automatic count_ticks(input int cycles, inout int t);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tick_o) t++;
        end
    endtask

    task automatic settle_disabled();
        @(negedge clk);
        run_en = 1'b0;
        pin_async = '0;
        for (int i = 0; i < 5; i++) @(negedge clk);
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int c;
        int t;
        int sd;
        sd = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        // R1: hardware reset state
        check(rd_data == 16'h0000, "R1 reset cfg", rd_data, 0);
        check(tick_o == 1'b0, "R1 reset tick", tick_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: write then read back, field layout
        write_cfg(14'h2A5C, 2'b10);
        check(rd_data == 16'hAA5C, "R2 readback", rd_data, 16'hAA5C);
        write_cfg(5, 0);
        check(rd_data == 16'h0005, "R2 readback2", rd_data, 5);

        // R4/R3: internal source, first tick at 2(N+1) edges
        @(negedge clk); run_en = 1'b1;
        edges_to_tick(100, c);
        check(c == 12, "R4 first tick N=5", c, 12);
        edges_to_tick(100, c);
        check(c == 12, "R3 period N=5", c, 12);
        settle_disabled();

        // R4: preload zero ticks every 2 cycles
        write_cfg(0, 0);
        @(negedge clk); run_en = 1'b1;
        t = 0;
        count_ticks(40, t);
        check(t == exp_int_ticks(0, 40), "R4 N=0 count", t, exp_int_ticks(0, 40));

        // R6: disabled gives no tick; R5: re-enable restarts from new preload
        write_cfg(3, 0);
        @(negedge clk); run_en = 1'b0;
        t = 0;
        count_ticks(30, t);
        check(t == 0, "R6 idle no tick", t, 0);
        @(negedge clk); run_en = 1'b1;
        edges_to_tick(100, c);
        check(c == 8, "R5 reload on enable", c, 8);
        for (int i = 0; i < 3; i++) @(negedge clk);
        @(negedge clk); run_en = 1'b0;
        @(negedge clk); run_en = 1'b1;
        edges_to_tick(100, c);
        check(c == 8, "R5 restart mid count", c, 8);
        settle_disabled();

        // R7: pin latency with preload 0
        write_cfg(0, 1);
        @(negedge clk); run_en = 1'b1;
        for (int i = 0; i < 3; i++) @(negedge clk);
        pin_async[0] = 1'b1;
        edges_to_tick(20, c);
        check(c == 3, "R7 pin0 latency", c, 3);
        // R8: falling edge not counted
        pin_async[0] = 1'b0;
        t = 0;
        count_ticks(8, t);
        check(t == 0, "R8 falling ignored", t, 0);
        // R8: unselected pins ignored
        for (int k = 0; k < 6; k++) begin
            pin_async[2:1] = 2'b11; @(negedge clk); @(negedge clk); @(negedge clk);
            if (tick_o) t++;
            pin_async[2:1] = 2'b00; @(negedge clk); @(negedge clk); @(negedge clk);
            if (tick_o) t++;
        end
        count_ticks(5, t);
        check(t == 0, "R8 unselected ignored", t, 0);
        settle_disabled();

        // R7: pin2 with selector 11
        write_cfg(0, 3);
        @(negedge clk); run_en = 1'b1;
        for (int i = 0; i < 3; i++) @(negedge clk);
        pin_async[2] = 1'b1;
        edges_to_tick(20, c);
        check(c == 3, "R7 pin2 latency", c, 3);
        settle_disabled();

        // R5: event arriving on the enabling cycle is not counted (N=0, pin1)
        write_cfg(0, 2);
        pin_async[1] = 1'b1;
        @(negedge clk);
        @(negedge clk); run_en = 1'b1;
        t = 0;
        count_ticks(8, t);
        check(t == 0, "R5 event on load dropped", t, 0);
        settle_disabled();

        // R3/R7/R8: random external runs
        for (int r = 0; r < 12; r++) begin
            int n;
            int ps;
            int k;
            n  = $urandom_range(0, 4);
            ps = $urandom_range(1, 3);
            k  = $urandom_range(3, 14);
            write_cfg(n, ps);
            @(negedge clk); run_en = 1'b1;
            @(negedge clk); @(negedge clk);
            t = 0;
            for (int p = 0; p < k; p++) begin
                int hi;
                int lo;
                hi = $urandom_range(2, 5);
                lo = $urandom_range(2, 5);
                pin_async[ps-1] = 1'b1;
                for (int j = 0; j < hi; j++) begin
                    for (int q = 0; q < 3; q++)
                        if (q != ps - 1) pin_async[q] = 1'($urandom_range(0, 1));
                    @(negedge clk);
                    if (tick_o) t++;
                end
                pin_async[ps-1] = 1'b0;
                count_ticks(lo, t);
            end
            count_ticks(6, t);
            check(t == exp_ext_ticks(n, k), "R3 random ext ticks", t, exp_ext_ticks(n, k));
            settle_disabled();
        end

        // R4: random internal runs
        for (int r = 0; r < 8; r++) begin
            int n;
            int m;
            n = $urandom_range(0, 9);
            m = $urandom_range(10, 120);
            write_cfg(n, 0);
            @(negedge clk); run_en = 1'b1;
            t = 0;
            count_ticks(m, t);
            check(t == exp_int_ticks(n, m), "R4 random int ticks", t, exp_int_ticks(n, m));
            settle_disabled();
        end

        // R1: software clear beats a write and clears configuration
        write_cfg(14'h1234, 1);
        @(negedge clk);
        soft_clr = 1'b1; wr_en = 1'b1; wr_data = 16'hFFFF;
        @(negedge clk);
        soft_clr = 1'b0; wr_en = 1'b0;
        check(rd_data == 16'h0000, "R1 soft clear", rd_data, 0);
        @(negedge clk); run_en = 1'b1;
        edges_to_tick(20, c);
        check(c == 2, "R1 cleared preload divides by one", c, 2);
        settle_disabled();

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule